// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with a small 16-bit register interface. A down-counter moves one step for each pulse of a slow `tick` input. Software keeps the counter from running out by writing a two-word key to a service register. If the counter reaches the end of its count, the block drives a timeout reset pulse toward the system reset controller. It also records the cause and can latch an external timeout signal. A programmable pre-timeout threshold raises an interrupt some ticks before expiry, so software has time to save state.

The enable bit, the interrupt settings and the power-down bit have write-once rules. The external timeout signal and the reset-cause record survive a system reset (`rst_n`) and are cleared only by a power-on reset (`por_n`). Three control bits let the counter pause while the chip is in debug halt, wait or stop mode. The block only observes those modes; it does not enter them.

Register addresses on `addr`: 0 control, 1 service, 2 pre-timeout, 3 power-down, 4 reset cause. Reads are combinational from `addr`. Any other address reads 0.

Top module: `key_watchdog`

## Requirements
- R1: After power-on reset the control register reads 0xFF31. Its layout is: bit0 enable, bit1 debug-suspend, bit2 wait-suspend, bit3 stop-suspend, bit4 software-reset (reads 1), bit5 external-assert (reads the inverse of `ext_tout`), bit6 external-on-timeout, bits15:8 timeout. After power-on reset the pre-timeout register reads 0x0004, the power-down register reads 0x0001 and the cause register reads 0x0001.
- R2: When the counter holds N (N ≥ 1), the Nth counting tick expires it. `tout_rst` is then high for PULSE_CYCLES clock cycles, the cause register reads 0x0002 (bit1 timeout), and the counter stops until a system reset.
- R3: Writing 0x5555 and then 0xAAAA to the service register reloads the counter from the timeout field. This happens only while the watchdog is enabled and has not expired.
- R4: Any other service-register value aborts a key sequence, and so does 0xAAAA with no 0x5555 before it. No refresh results. A new 0x5555 starts the sequence again.
- R5: A write to the timeout field does not change the running count. The field is loaded into the counter only when enable goes from 0 to 1 or on a valid refresh.
- R6: Writing 1 to the enable bit sets it. Writing 0 clears it only while the debug-suspend bit is already 1. While enable is 0 the counter does not count.
- R7: The pre-timeout register has the count in bits7:0, a status flag in bit14 and an interrupt enable in bit15. The flag sets when a tick brings the counter down to the count. `irq` is high while both the flag and bit15 are 1. Writing 1 to bit14 clears the flag.
- R8: The first write to the pre-timeout register locks bits 15 and 7:0 until the next reset. Later writes change only the flag, through its write-1-to-clear action.
- R9: Writing 0 to control bit4 gives a one-cycle `sw_rst` pulse and sets the cause register to 0x0004 (bit2 software). The bit still reads 1.
- R10: Writing 0 to control bit5 sets `ext_tout`. So does an expiry while bit6 is 1. `ext_tout` stays high through system resets until `por_n`.
- R11: Power-down register bit0 takes only its first write after a reset. That write can clear the bit but cannot set it.
- R12: While `lp_wait` and bit2 are both 1, ticks are ignored. The same holds for `lp_stop` with bit3 and for `dbg_halt` with bit1.
- R13: The cause register keeps its value through `rst_n` and always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick | input | 1 | Counting tick enable, one clock wide |
| lp_wait | input | 1 | Chip is in wait mode |
| lp_stop | input | 1 | Chip is in stop mode |
| dbg_halt | input | 1 | Chip is halted in debug |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Pre-timeout interrupt |
| tout_rst | output | 1 | Timeout reset pulse |
| sw_rst | output | 1 | Software reset request pulse |
| ext_tout | output | 1 | Latched external timeout signal |

## Verification
The expiry path is driven with different sequences of service writes between ticks. A correct key pair must move the expiry out by a full timeout. A reversed pair, or a pair broken by a stray value, must leave the expiry tick unchanged. Timeout-field writes without a refresh, enables cleared with and without the debug bit, and suspend modes are each shown by the tick on which `tout_rst` rises, which separates "loaded" from "not loaded" and "counting" from "held". Lock, clear-only and sticky rules are checked by a second write or a system reset, followed by a register read or an output check.

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter logic [7:0] TO_INIT      = 8'hFF,
  parameter logic [7:0] PRE_INIT     = 8'h04,
  parameter int         PULSE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lp_wait,
  input  logic        lp_stop,
  input  logic        dbg_halt,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        tout_rst,
  output logic        sw_rst,
  output logic        ext_tout
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_SVC = 3'd1, A_PRE = 3'd2, A_PDN = 3'd3, A_CAUSE = 3'd4;

  logic       en, dbg_sus, wait_sus, stop_sus, tout_ext;
  logic [7:0] to_val, cnt, pre_cnt;
  logic       pre_ie, pre_flag, pre_lock, pd_en, pd_lock, armed, expired;
  logic       ext_q;
  logic [2:0] cause;
  logic [PW-1:0] pcnt;

  wire wr_ctrl = rst_n && wr_en && addr == A_CTRL;
  wire wr_svc  = rst_n && wr_en && addr == A_SVC;
  wire wr_pre  = rst_n && wr_en && addr == A_PRE;
  wire wr_pdn  = rst_n && wr_en && addr == A_PDN;

  wire key_ok = wr_svc && wdata == 16'hAAAA && armed;
  wire reload = key_ok && en && !expired;
  wire en_set = wr_ctrl && wdata[0] && !en && !expired;
  wire hold   = (dbg_halt && dbg_sus) || (lp_wait && wait_sus) || (lp_stop && stop_sus);
  wire step   = rst_n && tick && en && !expired && !hold;
  wire fire   = step && cnt <= 8'd1;
  wire pre_hit = step && !fire && (cnt - 8'd1) == pre_cnt;

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) begin
      en <= 1'b1; dbg_sus <= 1'b0; wait_sus <= 1'b0; stop_sus <= 1'b0; tout_ext <= 1'b0;
      to_val <= TO_INIT; cnt <= TO_INIT; expired <= 1'b0; armed <= 1'b0;
      pre_cnt <= PRE_INIT; pre_ie <= 1'b0; pre_flag <= 1'b0; pre_lock <= 1'b0;
      pd_en <= 1'b1; pd_lock <= 1'b0; sw_rst <= 1'b0;
    end else begin
      sw_rst <= wr_ctrl && !wdata[4];
      if (wr_ctrl) begin
        to_val   <= wdata[15:8];
        dbg_sus  <= wdata[1];
        wait_sus <= wdata[2];
        stop_sus <= wdata[3];
        tout_ext <= wdata[6];
        if (wdata[0]) en <= 1'b1;
        else if (dbg_sus) en <= 1'b0;
      end
      if (wr_svc) armed <= wdata == 16'h5555;
      if (en_set) cnt <= wdata[15:8];
      else if (reload) cnt <= to_val;
      else if (step) cnt <= fire ? 8'd0 : cnt - 8'd1;
      if (fire) expired <= 1'b1;
      if (wr_pre) begin
        pre_lock <= 1'b1;
        if (!pre_lock) begin
          pre_ie  <= wdata[15];
          pre_cnt <= wdata[7:0];
        end
        if (wdata[14]) pre_flag <= 1'b0;
      end
      if (pre_hit) pre_flag <= 1'b1;
      if (wr_pdn) begin
        pd_lock <= 1'b1;
        if (!pd_lock) pd_en <= pd_en & wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ext_q <= 1'b0;
      cause <= 3'b001;
      pcnt  <= '0;
    end else begin
      if (fire) begin
        pcnt  <= PW'(PULSE_CYCLES);
        cause <= 3'b010;
        if (tout_ext) ext_q <= 1'b1;
      end else if (pcnt != '0) begin
        pcnt <= pcnt - 1'b1;
      end
      if (wr_ctrl && !wdata[5]) ext_q <= 1'b1;
      if (wr_ctrl && !wdata[4]) cause <= 3'b100;
    end
  end

  assign irq      = pre_flag && pre_ie;
  assign tout_rst = pcnt != '0;
  assign ext_tout = ext_q;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {to_val, 1'b0, tout_ext, ~ext_q, 1'b1, stop_sus, wait_sus, dbg_sus, en};
      A_PRE:   rdata = {pre_ie, pre_flag, 6'b0, pre_cnt};
      A_PDN:   rdata = {15'b0, pd_en};
      A_CAUSE: rdata = {13'b0, cause};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/key_watchdog_chk.sv
module key_watchdog_chk (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [15:0] wdata,
  input logic        sw_rst,
  input logic        ext_tout,
  input logic        en,
  input logic        dbg_sus,
  input logic        pre_lock,
  input logic        pre_ie,
  input logic [7:0]  pre_cnt,
  input logic        armed,
  input logic        expired,
  input logic [7:0]  cnt,
  input logic [7:0]  to_val,
  input logic [2:0]  cause
);
  a_r3_refresh_load: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && addr == 3'd1 && wdata == 16'hAAAA && armed && en && !expired) |=> cnt == $past(to_val));
  a_r2_stopped: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    expired |=> $stable(cnt));
  a_r6_en_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (en && !dbg_sus) |=> en);
  a_r8_pre_locked: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    pre_lock |=> ($stable(pre_cnt) && $stable(pre_ie)));
  a_r9_sw_single: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    sw_rst |=> !sw_rst);
  a_r10_ext_sticky: assert property (@(posedge clk) disable iff (!por_n)
    ext_tout |=> ext_tout);
  a_r13_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause) == 1);
endmodule

bind key_watchdog key_watchdog_chk chk_i (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sw_rst(sw_rst), .ext_tout(ext_tout), .en(en), .dbg_sus(dbg_sus), .pre_lock(pre_lock),
  .pre_ie(pre_ie), .pre_cnt(pre_cnt), .armed(armed), .expired(expired), .cnt(cnt),
  .to_val(to_val), .cause(cause)
);

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb_top;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b1, tick = 1'b0;
  logic lp_wait = 1'b0, lp_stop = 1'b0, dbg_halt = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'h0, rdata;
  logic irq, tout_rst, sw_rst, ext_tout;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  key_watchdog dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .lp_wait(lp_wait),
    .lp_stop(lp_stop), .dbg_halt(dbg_halt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tout_rst(tout_rst), .sw_rst(sw_rst), .ext_tout(ext_tout)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic refresh;
    wr(3'd1, 16'h5555); wr(3'd1, 16'hAAAA);
  endtask

  task automatic sys_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic po_reset;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1;
  endtask

  task automatic t_defaults;
    logic [15:0] d;
    po_reset();
    rd(3'd0, d); chk("R1 ctrl", d, 16'hFF31);
    rd(3'd2, d); chk("R1 pre", d, 16'h0004);
    rd(3'd3, d); chk("R1 pdn", d, 16'h0001);
    rd(3'd4, d); chk("R1 cause", d, 16'h0001);
    chk("R1 outputs", {12'b0, irq, tout_rst, sw_rst, ext_tout}, 16'h0);
  endtask

  task automatic t_expiry;
    logic [15:0] d;
    int n;
    sys_reset();
    wr(3'd0, 16'h0631); refresh();
    ticks(5); chk("R2 no early expiry", {15'b0, tout_rst}, 16'h0);
    ticks(1); chk("R2 expiry on tick 6", {15'b0, tout_rst}, 16'h1);
    n = 0;
    while (tout_rst && n < 20) begin n++; @(negedge clk); end
    chk("R2 pulse width", 16'(n), 16'd4);
    rd(3'd4, d); chk("R2 cause timeout", d, 16'h0002);
    refresh(); ticks(10);
    chk("R2 stopped after expiry", {15'b0, tout_rst}, 16'h0);
    sys_reset();
    rd(3'd4, d); chk("R13 cause kept over rst_n", d, 16'h0002);
  endtask

  task automatic t_refresh;
    sys_reset();
    wr(3'd0, 16'h0631); refresh();
    ticks(4); refresh();
    ticks(5); chk("R3 refresh postponed expiry", {15'b0, tout_rst}, 16'h0);
    ticks(1); chk("R3 expiry after reload", {15'b0, tout_rst}, 16'h1);
    sys_reset();
    wr(3'd0, 16'h0631); refresh();
    ticks(3);
    wr(3'd1, 16'hAAAA); wr(3'd1, 16'h5555); wr(3'd1, 16'h1234); wr(3'd1, 16'hAAAA);
    ticks(2); chk("R4 bad keys no refresh early", {15'b0, tout_rst}, 16'h0);
    ticks(1); chk("R4 bad keys keep expiry", {15'b0, tout_rst}, 16'h1);
  endtask

  task automatic t_timeout_load;
    sys_reset();
    wr(3'd0, 16'h0231);
    ticks(4); chk("R5 field not loaded on write", {15'b0, tout_rst}, 16'h0);
  endtask

  task automatic t_enable;
    logic [15:0] d;
    sys_reset();
    wr(3'd0, 16'h0231); refresh();
    wr(3'd0, 16'h0230);
    rd(3'd0, d); chk("R6 enable not cleared", d, 16'h0231);
    wr(3'd0, 16'h0233); wr(3'd0, 16'h0232);
    rd(3'd0, d); chk("R6 enable cleared in debug", d, 16'h0232);
    ticks(5); chk("R6 disabled no count", {15'b0, tout_rst}, 16'h0);
    wr(3'd0, 16'h0331);
    ticks(2); chk("R5 enable loads field early", {15'b0, tout_rst}, 16'h0);
    ticks(1); chk("R5 enable loads field", {15'b0, tout_rst}, 16'h1);
  endtask

  task automatic t_pretimeout;
    logic [15:0] d;
    sys_reset();
    wr(3'd2, 16'h8002);
    wr(3'd0, 16'h0631); refresh();
    ticks(3); chk("R7 irq not yet", {15'b0, irq}, 16'h0);
    ticks(1); chk("R7 irq at threshold", {15'b0, irq}, 16'h1);
    rd(3'd2, d); chk("R7 flag set", d, 16'hC002);
    wr(3'd2, 16'h0007);
    rd(3'd2, d); chk("R8 locked fields", d, 16'hC002);
    wr(3'd2, 16'h4000);
    rd(3'd2, d); chk("R7 flag cleared", d, 16'h8002);
    chk("R7 irq cleared", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_swreset;
    logic [15:0] d;
    sys_reset();
    wr(3'd0, 16'hFF21);
    chk("R9 pulse high", {15'b0, sw_rst}, 16'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {15'b0, sw_rst}, 16'h0);
    rd(3'd0, d); chk("R9 bit reads 1", d, 16'hFF31);
    rd(3'd4, d); chk("R9 cause software", d, 16'h0004);
  endtask

  task automatic t_ext;
    logic [15:0] d;
    po_reset();
    wr(3'd0, 16'hFF11);
    chk("R10 ext set by write", {15'b0, ext_tout}, 16'h1);
    rd(3'd0, d); chk("R10 ext reads inverse", d, 16'hFF11);
    sys_reset();
    chk("R10 ext survives rst_n", {15'b0, ext_tout}, 16'h1);
    po_reset();
    chk("R10 ext cleared by por", {15'b0, ext_tout}, 16'h0);
    wr(3'd0, 16'h0271); refresh(); ticks(2);
    chk("R10 ext on timeout", {14'b0, ext_tout, tout_rst}, 16'h3);
    po_reset();
  endtask

  task automatic t_pdn;
    logic [15:0] d;
    sys_reset();
    wr(3'd3, 16'h0000); wr(3'd3, 16'h0001);
    rd(3'd3, d); chk("R11 clear only", d, 16'h0000);
    sys_reset();
    wr(3'd3, 16'h0001); wr(3'd3, 16'h0000);
    rd(3'd3, d); chk("R11 write once", d, 16'h0001);
  endtask

  task automatic t_suspend;
    sys_reset();
    wr(3'd0, 16'h0335); refresh();
    lp_wait = 1'b1;
    ticks(6); chk("R12 wait holds count", {15'b0, tout_rst}, 16'h0);
    lp_wait = 1'b0;
    ticks(2); chk("R12 resumes early", {15'b0, tout_rst}, 16'h0);
    ticks(1); chk("R12 resumes expiry", {15'b0, tout_rst}, 16'h1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_defaults();
    t_expiry();
    t_refresh();
    t_timeout_load();
    t_enable();
    t_pretimeout();
    t_swreset();
    t_ext();
    t_pdn();
    t_suspend();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule